// File: doc/BRIEF.md
# Channel-List ADC Sequencer Front End

This block sits between a 16-bit register bus and a multiplexed 12-bit converter. Software loads a short list of conversion entries. Each entry names an input channel, a gain code, a polarity and single-ended or differential wiring. The block then sequences conversions through that list, placing each entry on the multiplexer outputs and handshaking with the converter through a start strobe and a done pulse. Results go into a result FIFO that software drains through the same bus.

Conversions are launched in one of three ways: by a bus read of the start address (software mode), by a scan-timer tick, or by an edge on an external trigger line. A software launch converts one entry and advances the list pointer. A scan or external trigger runs one full sweep of the list from its first entry. A status word reports converter activity, FIFO levels and three pending event flags, and an interrupt line summarises the pending flags behind a global enable.

Top module: `adc_seq_front`

## Requirements
- R1: After reset, a read of the status word (offset 0x04) returns 0x0004 (result FIFO empty, nothing else set), and `irq` and `cnv_start` are low.
- R2: A bus read of offset 0x00 while trigger mode (control word 1 at offset 0x00, bits 1:0) is 01 starts exactly one conversion, provided the sequencer is idle, the list is non-empty and both FIFOs are enabled. In modes 00, 10 or 11 that read starts nothing. `cnv_start` is a single-cycle pulse.
- R3: A write to offset 0x10 appends a list entry taken from bits 7:0: channel in bits 3:0, gain code in bits 5:4, unipolar in bit 6, differential in bit 7. The entry being converted is on `mux_chan`, `mux_gain`, `mux_unipolar` and `mux_diff` from the cycle of `cnv_start` until the conversion ends.
- R4: The list holds 16 entries. Status bit 1 is set when it holds 16, and a push to a full list is dropped.
- R5: After each conversion the list pointer moves to the next entry and wraps to entry 0 after the last stored entry. A wrap sets pending flag bit 10.
- R6: A read of offset 0x10 returns the oldest result. The converter code has bit 11 inverted (offset binary to two's complement) and is sign-extended to 16 bits.
- R7: The result FIFO holds 32 results. Status bit 2 is empty, bit 3 is set at 16 or more, and bit 4 is full. A result arriving when the FIFO is full is dropped. A read of an empty FIFO repeats the last value read.
- R8: Pending flag bit 8 is set when the result count reaches 16.
- R9: Any write to offset 0x04 clears all pending flags, and `irq` is low two cycles later. `irq` is high exactly when a pending flag is set and control word 1 bit 15 is set.
- R10: In mode 10, a `scan_tick` pulse while idle converts every list entry once, starting at entry 0. With control bit 2 (continuous) clear, only one sweep is accepted per write of control word 1. With bit 2 set, each later tick starts a new sweep.
- R11: In mode 11, an edge on `ext_trig` starts a sweep as in R10. The edge is rising with control bit 3 clear and falling with bit 3 set. The selected edge sets pending flag bit 9.
- R12: Control word 2 (offset 0x02) bit 9 enables the list and bit 10 enables the result FIFO. While a bit is clear, that FIFO is empty, pushes to it are dropped and no trigger starts a conversion.
- R13: Status bit 0 is set from the cycle of `cnv_start` until the last conversion of the run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| scan_tick | input | 1 | Scan-timer trigger pulse |
| ext_trig | input | 1 | External trigger level |
| cnv_start | output | 1 | Conversion start strobe |
| cnv_done | input | 1 | Conversion complete pulse |
| cnv_data | input | 12 | Converter code, offset binary, valid with `cnv_done` |
| mux_chan | output | 4 | Selected input channel |
| mux_gain | output | 2 | Gain code |
| mux_unipolar | output | 1 | Unipolar range select |
| mux_diff | output | 1 | Differential input select |
| irq | output | 1 | Interrupt request |

## Verification
The bench's converter model checks the multiplexer outputs at every start strobe against the list the bench loaded, so a pointer that fails to wrap, or a dropped push that still landed, shows as a wrong entry. The result FIFO is filled past capacity through repeated sweeps. A design that overwrote entries or miscounted the half-full boundary would return the wrong sequence, miss the half-full flag at the 16th result, or lose the repeat-last value on an empty read. Trigger handling is exercised from both sides. Scan ticks are tested with continuous mode clear (a second tick must do nothing) and with it set. External edges are tested with each polarity, confirming that the opposite edge is ignored. A software start read is tested in a hardware mode. Clearing an enable must empty its FIFO and block triggers, and a push made while the list is disabled must not reappear. The interrupt gate is checked with the enable clear while flags are pending, then after the enable is set and after a clear write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_SW   = 2'b01,
    TRIG_SCAN = 2'b10,
    TRIG_EXT  = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;

  // Packed so that bit positions match the list-entry write format.
  typedef struct packed {
    logic       diff;
    logic       unipolar;
    logic [1:0] gain;
    logic [3:0] chan;
  } list_entry_t;

  localparam logic [5:0] OFS_CTRL1 = 6'h00;  // write: control 1, read: software start
  localparam logic [5:0] OFS_CTRL2 = 6'h02;
  localparam logic [5:0] OFS_STAT  = 6'h04;  // read: status, write: clear pending
  localparam logic [5:0] OFS_DATA  = 6'h10;  // write: list push, read: result pop

endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             empty,
  output logic             half,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign half    = (cnt >= CW'(DEPTH/2));
  assign count   = cnt;
  assign push_ok = push && !full && !clear;
  assign pop_ok  = pop && !empty && !clear;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop_ok) begin
      rdata <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_list.sv
module adc_seq_list
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       push,
  input  list_entry_t                wdata,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output list_entry_t                rd_entry,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  list_entry_t   mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          push_ok;

  assign full     = (cnt == CW'(DEPTH));
  assign count    = cnt;
  assign push_ok  = push && !full && !clear;
  assign rd_entry = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push_ok) mem[cnt[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (push_ok) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  // control outputs
  output trig_mode_e        mode,
  output logic              continuous,
  output logic              falling,
  output logic              irq_en,
  output logic              list_en,
  output logic              res_en,
  output logic              ctrl1_wr,
  output logic              sw_start_rd,
  output logic              list_push,
  output list_entry_t       list_wdata,
  output logic              res_pop,
  // status and events
  input  logic              busy,
  input  logic              list_full,
  input  logic              res_empty,
  input  logic              res_half,
  input  logic              res_full,
  input  logic [DATA_W-1:0] res_word,
  input  logic              ext_evt,
  input  logic              list_evt,
  output logic              irq
);
  localparam int EXT_W = 16 - DATA_W;

  logic [2:0]  pend;       // [0] half-full, [1] external, [2] list wrap
  logic        half_q;
  logic        half_evt;
  logic        sel_res_q;
  logic [15:0] rd_q;
  logic [15:0] status;
  logic [15:0] res_fmt;
  logic        a_ctrl1, a_ctrl2, a_stat, a_data;

  assign a_ctrl1 = (bus_addr == ADDR_W'(OFS_CTRL1));
  assign a_ctrl2 = (bus_addr == ADDR_W'(OFS_CTRL2));
  assign a_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign a_data  = (bus_addr == ADDR_W'(OFS_DATA));

  assign ctrl1_wr    = bus_wr && a_ctrl1;
  assign sw_start_rd = bus_rd && a_ctrl1;
  assign list_push   = bus_wr && a_data && list_en;
  assign list_wdata  = list_entry_t'(bus_wdata[7:0]);
  assign res_pop     = bus_rd && a_data;
  assign half_evt    = res_half && !half_q;

  assign status = {3'b000, 2'b00, pend, 3'b000,
                   res_full, res_half, res_empty, list_full, busy};

  // Offset binary to two's complement, sign extended.
  assign res_fmt = {{EXT_W{~res_word[DATA_W-1]}}, ~res_word[DATA_W-1],
                    res_word[DATA_W-2:0]};

  assign bus_rdata = sel_res_q ? res_fmt : rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= TRIG_OFF;
      continuous <= 1'b0;
      falling    <= 1'b0;
      irq_en     <= 1'b0;
      list_en    <= 1'b0;
      res_en     <= 1'b0;
    end else begin
      if (ctrl1_wr) begin
        mode       <= trig_mode_e'(bus_wdata[1:0]);
        continuous <= bus_wdata[2];
        falling    <= bus_wdata[3];
        irq_en     <= bus_wdata[15];
      end
      if (bus_wr && a_ctrl2) begin
        list_en <= bus_wdata[9];
        res_en  <= bus_wdata[10];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      half_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      half_q <= res_half;
      if (bus_wr && a_stat) pend <= '0;
      else pend <= pend | {list_evt, ext_evt, half_evt};
      irq <= (|pend) && irq_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      sel_res_q <= 1'b0;
    end else begin
      sel_res_q <= bus_rd && a_data;
      if (bus_rd) rd_q <= a_stat ? status : 16'h0000;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int LIST_DEPTH = 16,
  parameter int DATA_W     = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  trig_mode_e                      mode,
  input  logic                            continuous,
  input  logic                            falling,
  input  logic                            ctrl1_wr,
  input  logic                            list_en,
  input  logic                            res_en,
  input  logic                            sw_start_rd,
  input  logic                            scan_tick,
  input  logic                            ext_trig,
  input  logic [$clog2(LIST_DEPTH+1)-1:0] list_cnt,
  output logic [$clog2(LIST_DEPTH)-1:0]   rd_idx,
  input  list_entry_t                     rd_entry,
  input  logic                            cnv_done,
  input  logic [DATA_W-1:0]               cnv_data,
  output logic                            cnv_start,
  output list_entry_t                     mux_q,
  output logic                            busy,
  output logic                            res_push,
  output logic [DATA_W-1:0]               res_wdata,
  output logic                            ext_evt,
  output logic                            list_evt
);
  localparam int IW = $clog2(LIST_DEPTH);
  localparam int CW = $clog2(LIST_DEPTH+1);

  seq_state_e    state;
  logic [IW-1:0] cur, nxt;
  logic          wrap;
  logic          sweeping, armed;
  logic          ext_q, ext_edge;
  logic          abort, can_go, sw_go, hw_go, finish;

  assign wrap     = ((CW'(cur) + CW'(1)) == list_cnt);
  assign nxt      = wrap ? '0 : cur + 1'b1;
  assign ext_edge = falling ? (ext_q && !ext_trig) : (!ext_q && ext_trig);
  assign abort    = (mode == TRIG_OFF) || !list_en || !res_en;
  assign can_go   = (state == SQ_IDLE) && !abort && (list_cnt != '0);
  assign sw_go    = can_go && sw_start_rd && (mode == TRIG_SW);
  assign hw_go    = can_go && armed &&
                    (((mode == TRIG_SCAN) && scan_tick) ||
                     ((mode == TRIG_EXT) && ext_edge));
  assign finish   = (state == SQ_WAIT) && cnv_done && !abort;

  always_comb begin
    if (state == SQ_IDLE) rd_idx = (mode == TRIG_SW) ? cur : '0;
    else                  rd_idx = nxt;
  end

  assign cnv_start = (state == SQ_START);
  assign busy      = (state != SQ_IDLE);
  assign res_push  = finish;
  assign res_wdata = cnv_data;
  assign list_evt  = finish && wrap;
  assign ext_evt   = (mode == TRIG_EXT) && ext_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cur      <= '0;
      sweeping <= 1'b0;
      armed    <= 1'b0;
      ext_q    <= 1'b0;
      mux_q    <= '0;
    end else begin
      ext_q <= ext_trig;
      if (ctrl1_wr) armed <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (sw_go) begin
            state <= SQ_START;
            mux_q <= rd_entry;
          end else if (hw_go) begin
            state    <= SQ_START;
            sweeping <= 1'b1;
            cur      <= '0;
            mux_q    <= rd_entry;
            if (!continuous) armed <= 1'b0;
          end
        end
        SQ_START: begin
          state <= abort ? SQ_IDLE : SQ_WAIT;
          if (abort) sweeping <= 1'b0;
        end
        SQ_WAIT: begin
          if (abort) begin
            state    <= SQ_IDLE;
            sweeping <= 1'b0;
          end else if (cnv_done) begin
            cur <= nxt;
            if (sweeping && !wrap) begin
              state <= SQ_START;
              mux_q <= rd_entry;
            end else begin
              state    <= SQ_IDLE;
              sweeping <= 1'b0;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
      if (!list_en) cur <= '0;
    end
  end
endmodule

// File: rtl/adc_seq_front.sv
module adc_seq_front
  import adc_seq_pkg::*;
#(
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 32,
  parameter int DATA_W     = 12,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              scan_tick,
  input  logic              ext_trig,
  output logic              cnv_start,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data,
  output logic [3:0]        mux_chan,
  output logic [1:0]        mux_gain,
  output logic              mux_unipolar,
  output logic              mux_diff,
  output logic              irq
);
  localparam int LIW = $clog2(LIST_DEPTH);
  localparam int LCW = $clog2(LIST_DEPTH+1);
  localparam int RCW = $clog2(RES_DEPTH+1);

  trig_mode_e        mode;
  logic              continuous, falling, irq_en, list_en, res_en;
  logic              ctrl1_wr, sw_start_rd, list_push, res_pop;
  list_entry_t       list_wdata, rd_entry, mux_q;
  logic [LIW-1:0]    rd_idx;
  logic [LCW-1:0]    list_cnt;
  logic              list_full;
  logic [RCW-1:0]    res_cnt;
  logic              res_empty, res_half, res_full;
  logic              res_push;
  logic [DATA_W-1:0] res_wdata, res_word;
  logic              busy, ext_evt, list_evt;

  adc_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode(mode), .continuous(continuous), .falling(falling), .irq_en(irq_en),
    .list_en(list_en), .res_en(res_en), .ctrl1_wr(ctrl1_wr),
    .sw_start_rd(sw_start_rd), .list_push(list_push), .list_wdata(list_wdata),
    .res_pop(res_pop), .busy(busy), .list_full(list_full),
    .res_empty(res_empty), .res_half(res_half), .res_full(res_full),
    .res_word(res_word), .ext_evt(ext_evt), .list_evt(list_evt), .irq(irq)
  );

  adc_seq_list #(.DEPTH(LIST_DEPTH)) u_list (
    .clk(clk), .rst(rst), .clear(!list_en), .push(list_push),
    .wdata(list_wdata), .rd_idx(rd_idx), .rd_entry(rd_entry),
    .count(list_cnt), .full(list_full)
  );

  adc_seq_fifo #(.WIDTH(DATA_W), .DEPTH(RES_DEPTH)) u_res (
    .clk(clk), .rst(rst), .clear(!res_en), .push(res_push),
    .wdata(res_wdata), .pop(res_pop), .rdata(res_word), .count(res_cnt),
    .empty(res_empty), .half(res_half), .full(res_full)
  );

  adc_seq_ctrl #(.LIST_DEPTH(LIST_DEPTH), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .continuous(continuous),
    .falling(falling), .ctrl1_wr(ctrl1_wr), .list_en(list_en),
    .res_en(res_en), .sw_start_rd(sw_start_rd), .scan_tick(scan_tick),
    .ext_trig(ext_trig), .list_cnt(list_cnt), .rd_idx(rd_idx),
    .rd_entry(rd_entry), .cnv_done(cnv_done), .cnv_data(cnv_data),
    .cnv_start(cnv_start), .mux_q(mux_q), .busy(busy),
    .res_push(res_push), .res_wdata(res_wdata), .ext_evt(ext_evt),
    .list_evt(list_evt)
  );

  assign mux_chan     = mux_q.chan;
  assign mux_gain     = mux_q.gain;
  assign mux_unipolar = mux_q.unipolar;
  assign mux_diff     = mux_q.diff;
endmodule

// File: rtl/adc_seq_front_chk.sv
module adc_seq_front_chk #(
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 32,
  parameter int ADDR_W     = 6
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            bus_wr,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic                            cnv_start,
  input logic                            busy,
  input logic [3:0]                      mux_chan,
  input logic [1:0]                      mux_gain,
  input logic                            mux_unipolar,
  input logic                            mux_diff,
  input logic                            irq,
  input logic [$clog2(LIST_DEPTH+1)-1:0] list_cnt,
  input logic [$clog2(RES_DEPTH+1)-1:0]  res_cnt
);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cnv_start |=> !cnv_start);

  assert_mux_hold_R3: assert property (@(posedge clk) disable iff (rst)
    cnv_start |=> $stable({mux_diff, mux_unipolar, mux_gain, mux_chan}));

  assert_list_cap_R4: assert property (@(posedge clk) disable iff (rst)
    list_cnt <= ($clog2(LIST_DEPTH+1))'(LIST_DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    res_cnt <= ($clog2(RES_DEPTH+1))'(RES_DEPTH));

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(6'h04)) |-> ##2 !irq);

  assert_active_R13: assert property (@(posedge clk) disable iff (rst)
    cnv_start |-> busy);
endmodule

bind adc_seq_front adc_seq_front_chk #(
  .LIST_DEPTH(LIST_DEPTH), .RES_DEPTH(RES_DEPTH), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cnv_start(cnv_start), .busy(busy), .mux_chan(mux_chan),
  .mux_gain(mux_gain), .mux_unipolar(mux_unipolar), .mux_diff(mux_diff),
  .irq(irq), .list_cnt(list_cnt), .res_cnt(res_cnt)
);

// File: tb/adc_seq_front_bench.sv
`timescale 1ns/1ps
module adc_seq_front_bench;
  localparam logic [5:0] A_C1 = 6'h00, A_C2 = 6'h02, A_ST = 6'h04, A_DT = 6'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        scan_tick = 1'b0, ext_trig = 1'b0;
  logic        cnv_start, cnv_done = 1'b0;
  logic [11:0] cnv_data = '0;
  logic [3:0]  mux_chan;
  logic [1:0]  mux_gain;
  logic        mux_unipolar, mux_diff, irq;

  int checks = 0, errors = 0;
  logic [7:0]  lst [16];
  int          lst_n = 0, exp_idx = 0, seq = 0;
  logic [11:0] q [$];
  logic [15:0] s, v, last;

  always #2.5 clk = ~clk;

  adc_seq_front u_adc_seq_front (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scan_tick(scan_tick), .ext_trig(ext_trig), .cnv_start(cnv_start),
    .cnv_done(cnv_done), .cnv_data(cnv_data), .mux_chan(mux_chan),
    .mux_gain(mux_gain), .mux_unipolar(mux_unipolar), .mux_diff(mux_diff),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [11:0] c);
    return {{4{~c[11]}}, ~c[11], c[10:0]};
  endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    for (int i = 0; i < 400; i++) begin
      rd(A_ST, st);
      if (!st[0]) break;
    end
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_entry(input logic [7:0] e);
    wr(A_DT, {8'h00, e});
    if (lst_n < 16) begin lst[lst_n] = e; lst_n++; end
  endtask

  task automatic tick();
    @(negedge clk); scan_tick = 1'b1;
    @(negedge clk); scan_tick = 1'b0;
    wait_idle();
  endtask

  task automatic drain(input string tag);
    logic [15:0] d;
    int n;
    n = q.size();
    for (int i = 0; i < n; i++) begin
      rd(A_DT, d);
      check(tag, d, fmt(q.pop_front()));
      last = d;
    end
    rd(A_ST, d);
    check({tag, " empty after drain"}, d[2], 1'b1);
  endtask

  // Behavioural converter: checks the multiplexer entry, answers after a delay.
  initial begin
    logic [7:0]  ent;
    logic [11:0] code;
    forever begin
      @(negedge clk);
      cnv_done = 1'b0;
      if (cnv_start) begin
        ent = {mux_diff, mux_unipolar, mux_gain, mux_chan};
        check("R3 mux entry at start", ent, lst[exp_idx]);
        exp_idx = (lst_n == 0) ? 0 : (exp_idx + 1) % lst_n;
        code = {seq[3:0], ent};
        seq++;
        if (q.size() < 32) q.push_back(code);
        repeat (2) @(negedge clk);
        cnv_data = code;
        cnv_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_ST, s);
    check("R1 status after reset", s, 16'h0004);
    check("R1 irq after reset", irq, 1'b0);
    check("R1 start after reset", cnv_start, 1'b0);

    wr(A_C2, 16'h0600);
    push_entry(8'h05);
    push_entry(8'h9A);
    push_entry(8'h6F);

    // R2 start read ignored with triggers off
    rd(A_C1, v); idle_cycles(8);
    rd(A_ST, s);
    check("R2 no conversion in mode off", s, 16'h0004);

    // R2 / R13 / R5 software starts with wrap
    wr(A_C1, 16'h0001);
    rd(A_C1, v);
    rd(A_ST, s);
    check("R13 active during conversion", s[0], 1'b1);
    wait_idle();
    for (int i = 0; i < 3; i++) begin rd(A_C1, v); wait_idle(); end
    check("R2 one result per start read", q.size(), 4);
    rd(A_ST, s);
    check("R5 wrap flag set, fifo not empty", s & 16'h0405, 16'h0400);
    drain("R6 result order and format");
    rd(A_DT, v);
    check("R7 empty pop repeats last", v, last);

    // R2 start read in scan mode, R10 single sweep
    wr(A_C1, 16'h0002);
    rd(A_C1, v); idle_cycles(8);
    check("R2 start read ignored in scan mode", q.size(), 0);
    exp_idx = 0;
    tick();
    tick();
    check("R10 one sweep without continuous", q.size(), 3);
    drain("R6 scan results");

    // R10 continuous
    wr(A_C1, 16'h0006);
    exp_idx = 0;
    tick();
    tick();
    check("R10 continuous repeats sweep", q.size(), 6);
    drain("R6 continuous results");

    wr(A_ST, 16'h0000);
    rd(A_ST, s);
    check("R9 clear write empties pending", s, 16'h0004);

    // R11 external edges
    wr(A_C1, 16'h0007);
    exp_idx = 0;
    @(negedge clk); ext_trig = 1'b1;
    idle_cycles(2); wait_idle();
    check("R11 rising edge sweep", q.size(), 3);
    rd(A_ST, s);
    check("R11 external flag", s[9], 1'b1);
    @(negedge clk); ext_trig = 1'b0;
    idle_cycles(12);
    check("R11 falling ignored in rising mode", q.size(), 3);
    drain("R6 external results");
    wr(A_C1, 16'h000F);
    exp_idx = 0;
    @(negedge clk); ext_trig = 1'b1;
    idle_cycles(12);
    check("R11 rising ignored in falling mode", q.size(), 0);
    @(negedge clk); ext_trig = 1'b0;
    idle_cycles(2); wait_idle();
    check("R11 falling edge sweep", q.size(), 3);
    drain("R6 falling results");

    // R9 interrupt gating
    idle_cycles(2);
    check("R9 irq low with enable clear", irq, 1'b0);
    wr(A_C1, 16'h8001);
    idle_cycles(2);
    check("R9 irq with enable and pending", irq, 1'b1);
    wr(A_ST, 16'h0000);
    idle_cycles(2);
    check("R9 irq low after clear", irq, 1'b0);
    exp_idx = 0;
    for (int i = 0; i < 3; i++) begin rd(A_C1, v); wait_idle(); end
    idle_cycles(2);
    check("R9 irq on new wrap event", irq, 1'b1);
    wr(A_ST, 16'h0000);
    drain("R6 irq test results");

    // R7 / R8 fill beyond capacity
    wr(A_C1, 16'h0006);
    exp_idx = 0;
    for (int i = 0; i < 5; i++) tick();
    rd(A_ST, s);
    check("R8 below half no flag", {s[8], s[3]}, 2'b00);
    tick();
    rd(A_ST, s);
    check("R8 half reached sets flag", {s[8], s[3]}, 2'b11);
    for (int i = 0; i < 5; i++) tick();
    rd(A_ST, s);
    check("R7 full flag", s[4], 1'b1);
    check("R7 bench capped at capacity", q.size(), 32);
    drain("R7 capacity contents");
    rd(A_DT, v);
    check("R7 empty pop after full drain", v, last);

    // R4 / R12 list capacity and disabled push
    wr(A_C2, 16'h0400);
    lst_n = 0; exp_idx = 0;
    rd(A_ST, s);
    check("R12 list cleared", s[1], 1'b0);
    wr(A_DT, 16'h0033);
    wr(A_C2, 16'h0600);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) begin
        rd(A_ST, s);
        check("R4 not full at 15", s[1], 1'b0);
      end
      push_entry(8'((i * 27) ^ 8'h40));
    end
    rd(A_ST, s);
    check("R4 full at 16", s[1], 1'b1);
    wr(A_DT, 16'h00FF);
    wr(A_C1, 16'h0002);
    exp_idx = 0;
    tick();
    check("R4 sweep covers 16 entries", q.size(), 16);
    drain("R12 entries exclude disabled push");

    // R12 result FIFO disable
    wr(A_C1, 16'h0001);
    exp_idx = 0;
    rd(A_C1, v); wait_idle();
    rd(A_C1, v); wait_idle();
    wr(A_C2, 16'h0200);
    q.delete();
    rd(A_ST, s);
    check("R12 results cleared", s[2], 1'b1);
    rd(A_C1, v); idle_cycles(10);
    check("R12 no start with results disabled", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule